// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with High and Low Result Registers

This block does integer multiplication and division for a 32-bit RISC-style core. The core starts an operation by presenting two operands and a two-bit operation code. The unit then works on it one bit per clock: shift-add for multiply and restoring subtraction for divide. Its results never go straight to a general register. They are written into a pair of dedicated result registers, called high and low. Multiply places the upper half of the double-width product in high and the lower half in low. Divide places the remainder in high and the quotient in low.

The core reads the pair only through separate move-from-high and move-from-low requests, and each request returns one register. While an operation is in flight, the unit raises `busy`. A read request that arrives during that time sees `stall`, so the pipeline can hold the read until the result is written. A one-cycle `done` pulse marks the first cycle in which the new results can be read. Signed operands are handled by working on magnitudes and then correcting the sign of the result at completion.

Top module: `muldiv_unit`

## Requirements
- R1: The operand and result width is the parameter WIDTH, 32 by default. opCode selects the operation: 2'b00 is signed multiply, 2'b01 is unsigned multiply, 2'b10 is signed divide and 2'b11 is unsigned divide.
- R2: Multiply forms the full 2*WIDTH product of the operands, read as two's-complement for 2'b00 and unsigned for 2'b01. The upper WIDTH bits go to high and the lower WIDTH bits go to low.
- R3: Unsigned divide with a non-zero divisor places floor(a/b) in low and a mod b in high.
- R4: Signed divide with a non-zero divisor truncates the quotient toward zero, and the remainder carries the sign of the dividend. The most negative value divided by -1 gives the most negative value as quotient and zero as remainder.
- R5: Division by zero, signed or unsigned, takes the normal number of cycles and leaves low all ones and high equal to the dividend.
- R6: A start is accepted at a rising edge where startValid is 1 and busy is 0. busy is then 1 for exactly WIDTH+1 cycles. done is 1 for exactly one cycle, the first cycle with busy back at 0, and the new results are readable in that cycle.
- R7: startValid while busy is 1 is ignored. It does not change the in-flight result, the busy length, or whether a further operation starts.
- R8: With readHi at 1, readData returns high. With only readLo at 1, readData returns low. readHi takes priority when both are 1. readValid is 1 when a read is requested and busy is 0.
- R9: A read request while busy is 1 gives stall 1 and readValid 0. When busy falls, a request that is still held is served in that same cycle.
- R10: After reset, busy, done and stall are 0, and both high and low read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start request for a new operation |
| opCode | input | 2 | Operation select (see R1) |
| opA | input | WIDTH | Multiplicand or dividend |
| opB | input | WIDTH | Multiplier or divisor |
| readHi | input | 1 | Move-from-high request |
| readLo | input | 1 | Move-from-low request |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Read request held off while busy |
| readValid | output | 1 | readData is valid for the current request |
| readData | output | WIDTH | Selected result register |

## Verification
The bench sweeps every operand pair for all four operations at a 4-bit width, so every sign combination and every zero divisor is covered. The most negative dividend over -1 is part of that sweep. A design with a wrong sign fixup would return an off-by-sign quotient or remainder there. A design that let a zero divisor take the sign correction would return 1 instead of all ones for negative dividends. A separate pass fires a second start mid-operation: a unit that accepted it would lengthen busy or corrupt the result. A read held across completion must stall until busy drops and then return the fresh value in that same cycle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdOp_e;

  // strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic load;       // capture operands and mode
    logic step;       // one shift-add / restoring iteration
    logic writeBack;  // sign fixup and commit to high/low
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } ctrlState_e;

  ctrlState_e      state;
  logic [CW-1:0]   iterLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      iterLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (startValid) begin
            state    <= ST_RUN;
            iterLeft <= CW'(WIDTH);
          end
        end
        ST_RUN: begin
          iterLeft <= iterLeft - CW'(1);
          if (iterLeft == CW'(1)) begin
            state <= ST_FIN;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strobe.load      = (state == ST_IDLE) && startValid;
    strobe.step      = (state == ST_RUN);
    strobe.writeBack = (state == ST_FIN);
    busy             = (state != ST_IDLE);
  end

endmodule

// File: rtl/muldiv_dpath.sv
module muldiv_dpath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdStrobe_t        strobe,
  input  logic [1:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readHi,
  input  logic             readLo,
  output logic [WIDTH-1:0] readData
);

  localparam int W  = WIDTH;
  localparam int PW = 2 * WIDTH;

  // operand conditioning: both operands go through the same path
  logic                isSignedIn;
  logic                isDivIn;
  logic [1:0][W-1:0]   opIn;
  logic [1:0]          opNeg;
  logic [1:0][W-1:0]   opMag;

  assign isSignedIn = (opCode == OP_MUL_S) || (opCode == OP_DIV_S);
  assign isDivIn    = (opCode == OP_DIV_S) || (opCode == OP_DIV_U);
  assign opIn[0]    = opA;
  assign opIn[1]    = opB;

  for (genvar g = 0; g < 2; g++) begin : g_cond
    assign opNeg[g] = isSignedIn & opIn[g][W-1];
    assign opMag[g] = opNeg[g] ? (~opIn[g] + W'(1)) : opIn[g];
  end

  // working state
  logic         isDiv;
  logic         negRes;
  logic         negRem;
  logic         divZero;
  logic [W-1:0] accHi;
  logic [W-1:0] accLo;
  logic [W-1:0] mcand;
  logic [W-1:0] hiReg;
  logic [W-1:0] loReg;

  // one iteration of each algorithm
  logic [W:0]   mulSum;
  logic [W:0]   divShift;
  logic [W:0]   divTrial;
  logic         divGe;
  logic [W-1:0] nextHi;
  logic [W-1:0] nextLo;

  always_comb begin
    mulSum   = {1'b0, accHi} + (accLo[0] ? {1'b0, mcand} : '0);
    divShift = {accHi, accLo[W-1]};
    divTrial = divShift - {1'b0, mcand};
    divGe    = ~divTrial[W];
    if (isDiv) begin
      nextHi = divGe ? divTrial[W-1:0] : divShift[W-1:0];
      nextLo = {accLo[W-2:0], divGe};
    end else begin
      nextHi = mulSum[W:1];
      nextLo = {mulSum[0], accLo[W-1:1]};
    end
  end

  // sign correction at completion
  logic [PW-1:0] prodRaw;
  logic [PW-1:0] prodFix;
  logic [W-1:0]  quoFix;
  logic [W-1:0]  remFix;

  always_comb begin
    prodRaw = {accHi, accLo};
    prodFix = negRes ? (~prodRaw + PW'(1)) : prodRaw;
    quoFix  = (negRes && !divZero) ? (~accLo + W'(1)) : accLo;
    remFix  = negRem ? (~accHi + W'(1)) : accHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isDiv   <= 1'b0;
      negRes  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
      accHi   <= '0;
      accLo   <= '0;
      mcand   <= '0;
    end else if (strobe.load) begin
      isDiv   <= isDivIn;
      negRes  <= opNeg[0] ^ opNeg[1];
      negRem  <= opNeg[0];
      divZero <= (opB == '0);
      accHi   <= '0;
      accLo   <= opMag[0];
      mcand   <= opMag[1];
    end else if (strobe.step) begin
      accHi <= nextHi;
      accLo <= nextLo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobe.writeBack) begin
      if (isDiv) begin
        hiReg <= remFix;
        loReg <= quoFix;
      end else begin
        hiReg <= prodFix[PW-1:W];
        loReg <= prodFix[W-1:0];
      end
    end
  end

  always_comb begin
    if (readHi)      readData = hiReg;
    else if (readLo) readData = loReg;
    else             readData = '0;
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [1:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             readHi,
  input  logic             readLo,
  output logic             busy,
  output logic             done,
  output logic             stall,
  output logic             readValid,
  output logic [WIDTH-1:0] readData
);

  mdStrobe_t strobe;
  logic      readReq;

  muldiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  muldiv_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .readHi   (readHi),
    .readLo   (readLo),
    .readData (readData)
  );

  assign readReq   = readHi | readLo;
  assign stall     = readReq & busy;
  assign readValid = readReq & ~busy;

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int WIDTH = 32
) (
  input logic clk,
  input logic rstN,
  input logic startValid,
  input logic readHi,
  input logic readLo,
  input logic busy,
  input logic done,
  input logic stall,
  input logic readValid
);

  localparam int BW = $clog2(WIDTH + 2) + 1;

  logic [BW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + BW'(1);
    else           busyCnt <= '0;
  end

  // R6: an accepted start makes the unit busy on the next cycle
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done marks the first idle cycle after a busy period
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R6, R7: busy never runs longer than WIDTH+1 cycles
  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt <= BW'(WIDTH)));

  // R6: busy ends after exactly WIDTH+1 cycles
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == BW'(WIDTH + 1)));

  // R9: a stalled request never also reports valid data
  a_r9_stall_excl: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !readValid);

  // R8: valid data only answers a request
  a_r8_valid_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    readValid |-> (readHi || readLo));

endmodule

bind muldiv_unit muldiv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .readHi     (readHi),
  .readLo     (readLo),
  .busy       (busy),
  .done       (done),
  .stall      (stall),
  .readValid  (readValid)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startValid = 1'b0;
  logic [1:0]   opCode = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         readHi = 1'b0;
  logic         readLo = 1'b0;
  logic         busy;
  logic         done;
  logic         stall;
  logic         readValid;
  logic [W-1:0] readData;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  muldiv_unit #(.WIDTH(W)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .opCode     (opCode),
    .opA        (opA),
    .opB        (opB),
    .readHi     (readHi),
    .readLo     (readLo),
    .busy       (busy),
    .done       (done),
    .stall      (stall),
    .readValid  (readValid),
    .readData   (readData)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int toSigned(input int v);
    return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  // expected high/low from the requirements
  task automatic model(input int op, input int a, input int b,
                       output int eh, output int el);
    int sa = toSigned(a);
    int sb = toSigned(b);
    int p;
    case (op)
      0: begin p = (sa * sb) & ((1 << (2 * W)) - 1); eh = p >> W; el = p & MASK; end
      1: begin p = a * b; eh = p >> W; el = p & MASK; end
      2: begin
        if (b == 0) begin el = MASK; eh = a; end
        else begin el = (sa / sb) & MASK; eh = (sa % sb) & MASK; end
      end
      default: begin
        if (b == 0) begin el = MASK; eh = a; end
        else begin el = a / b; eh = a % b; end
      end
    endcase
  endtask

  task automatic readReg(input bit hi, output int val, output int vld);
    readHi = hi;
    readLo = !hi;
    #2;
    val = int'(readData);
    vld = int'(readValid);
    @(negedge clk);
    readHi = 1'b0;
    readLo = 1'b0;
  endtask

  // start an operation; returns busy length and done at the end
  task automatic launch(input int op, input int a, input int b,
                        output int busyLen, output int doneSeen);
    while (busy) @(negedge clk);
    startValid = 1'b1;
    opCode = 2'(op);
    opA = W'(a);
    opB = W'(b);
    @(negedge clk);
    startValid = 1'b0;
    busyLen = 0;
    while (busy) begin
      busyLen++;
      @(negedge clk);
    end
    doneSeen = int'(done);
  endtask

  function automatic string tagFor(input int op, input int b);
    if (op >= 2 && b == 0) return "R5";
    case (op)
      0, 1:    return "R1/R2";
      2:       return "R1/R4";
      default: return "R1/R3";
    endcase
  endfunction

  initial begin
    int eh, el, hv, lv, vld, bl, dn;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 stall", int'(stall), 0);
    readReg(1'b1, hv, vld);
    check("R10 high", hv, 0);
    readReg(1'b0, lv, vld);
    check("R10 low", lv, 0);

    // full sweep over every operation and operand pair
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          launch(op, a, b, bl, dn);
          check("R6 busy length", bl, W + 1);
          check("R6 done", dn, 1);
          model(op, a, b, eh, el);
          readReg(1'b1, hv, vld);
          check({tagFor(op, b), " high"}, hv, eh);
          check("R8 readValid", vld, 1);
          readReg(1'b0, lv, vld);
          check({tagFor(op, b), " low"}, lv, el);
        end
      end
    end

    // R7: start during busy is ignored
    while (busy) @(negedge clk);
    startValid = 1'b1; opCode = 2'b01; opA = 4'd3; opB = 4'd5;
    @(negedge clk);
    startValid = 1'b0;
    @(negedge clk);
    startValid = 1'b1; opCode = 2'b11; opA = 4'd7; opB = 4'd2;
    @(negedge clk);
    startValid = 1'b0;
    bl = 2;
    while (busy) begin bl++; @(negedge clk); end
    check("R7 busy length", bl, W + 1);
    @(negedge clk);
    check("R7 no second start", int'(busy), 0);
    readReg(1'b1, hv, vld);
    check("R7 high", hv, 0);
    readReg(1'b0, lv, vld);
    check("R7 low", lv, 15);

    // R9: read held across completion
    startValid = 1'b1; opCode = 2'b11; opA = 4'd13; opB = 4'd4;
    @(negedge clk);
    startValid = 1'b0;
    readLo = 1'b1;
    #2;
    check("R9 stall", int'(stall), 1);
    check("R9 readValid low", int'(readValid), 0);
    while (busy) @(negedge clk);
    #2;
    check("R9 stall released", int'(stall), 0);
    check("R9 served valid", int'(readValid), 1);
    check("R9 served data", int'(readData), 3);
    // R8: both requests -> high wins
    readHi = 1'b1;
    #2;
    check("R8 priority high", int'(readData), 1);
    @(negedge clk);
    readHi = 1'b0;
    readLo = 1'b0;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R6 watchdog: cycles=150000 expected fewer");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule